// File: doc/BRIEF.md
# Enable-Gated Address Window Decoder

The block decides which of four address windows an incoming 64-bit system address falls into, and where inside that window it lands. Two windows are general purpose: each has a programmable base and a programmable mask that sets its size. The third window covers a register file and the fourth covers an interrupt area. Both have fixed sizes set by parameters. Software programs bases and masks through a write-only style register port with combinational readback. It then switches windows on through an enable register.

Lookups travel as a valid/ready stream. An address is accepted on any clock edge where `in_valid` and `in_ready` are both high. One edge later the block presents a one-hot hit vector, a miss flag and the offset inside the hit window. The output stage holds one result. It accepts a new address only when it is empty or when its result is taken in the same cycle (`in_ready = !out_valid || out_ready`). While `out_ready` is low, a presented result stays unchanged.

Each window's base and size are captured when its enable bit goes from 0 to 1. Later writes to a base or mask register are stored and can be read back, but they do not move a window that is already enabled. Such a write also raises a one-cycle warning.

Top module: `window_decoder`

## Requirements
- R1: Configuration select codes are 0 general window 0 base, 1 general window 0 mask, 2 general window 1 base, 3 general window 1 mask, 4 register window base, 5 interrupt window base, 6 enable, 7 mode. A write to codes 0 to 3 stores only bits 63:24, and the low 24 bits read back as zero.
- R2: A write to code 4 stores only bits 63:22. A write to code 5 stores only bits 63:36. A write to code 7 stores only bits 63:56. `cfg_rdata` always shows the stored value of the register selected by `cfg_sel`.
- R3: A write to code 6 stores only bits 63:60. Bit 63 enables general window 0, bit 62 general window 1, bit 61 the register window and bit 60 the interrupt window. An enable change applies to every lookup accepted after the write edge; a lookup accepted on the write edge itself still sees the old enables.
- R4: A general window's base is its stored base register shifted right by 8. Its size is ((~mask) >> 8) + 1. An address hits the window when base <= addr < base + size.
- R5: The register window has base (code 4 register >> 8) and size NUM_REGS*8 bytes. The interrupt window has base (code 5 register >> 8) and size NUM_INTS*65536 bytes.
- R6: On a hit, `out_offset` is addr minus the hit window's base. With no hit, `out_hit` is zero, `out_miss` is high and `out_offset` is zero.
- R7: `out_hit` is one-hot, with bit i meaning window i. When windows overlap, the lowest-numbered window wins.
- R8: A write to codes 0 to 3 while either general enable is set, to code 4 while the register window is enabled, or to code 5 while the interrupt window is enabled raises `cfg_warn` for exactly the cycle after the write edge. The value is still stored. No other write raises it.
- R9: Base and size are captured from the registers when the window's enable rises. Rewriting the base of an enabled window leaves decoding unchanged until the window is disabled and enabled again.
- R10: The stream obeys `in_ready = !out_valid || out_ready`. A result appears one edge after acceptance and holds stable while `out_ready` is low.
- R11: After reset, all configuration registers read zero, no window is enabled, `out_valid` and `cfg_warn` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select (write and readback) |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Stored value of the selected register |
| cfg_warn | output | 1 | Pulse: an enabled window's register was rewritten |
| in_valid | input | 1 | Lookup address valid |
| in_ready | output | 1 | Lookup address can be accepted |
| in_addr | input | 64 | System address to decode |
| out_valid | output | 1 | Decode result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 4 | One-hot window hit |
| out_miss | output | 1 | No enabled window contains the address |
| out_offset | output | 64 | Address offset inside the hit window |

## Verification
Two functions can land on the same clock edge. A lookup can be accepted on the edge where the enable register is written. A lookup can also run right after a base register of a live window was rewritten. The bench drives a disabling enable write and a lookup in one cycle, and expects the result to follow the old window set, with the next lookup following the new one. It also rewrites a live window's base and expects the warning pulse, readback of the new value, and hits still at the old base until the window is re-enabled.

// File: rtl/wdec_pkg.sv
package wdec_pkg;
  localparam int unsigned ADDR_W     = 64;
  localparam int unsigned NUM_WIN    = 4;
  localparam int unsigned NUM_GWIN   = 2;
  localparam int unsigned NUM_CFG    = 8;
  localparam int unsigned SEL_W      = $clog2(NUM_CFG);
  localparam int unsigned BASE_SHIFT = 8;

  typedef logic [ADDR_W-1:0] word_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_G0_BASE  = 3'd0,
    SEL_G0_MASK  = 3'd1,
    SEL_G1_BASE  = 3'd2,
    SEL_G1_MASK  = 3'd3,
    SEL_REG_BASE = 3'd4,
    SEL_INT_BASE = 3'd5,
    SEL_ENABLE   = 3'd6,
    SEL_MODE     = 3'd7
  } cfg_sel_e;

  // implemented bits per register class
  localparam word_t KEEP_GWIN = 64'hFFFF_FFFF_FF00_0000;
  localparam word_t KEEP_RWIN = 64'hFFFF_FFFF_FFC0_0000;
  localparam word_t KEEP_IWIN = 64'hFFFF_FFF0_0000_0000;
  localparam word_t KEEP_EN   = 64'hF000_0000_0000_0000;
  localparam word_t KEEP_MODE = 64'hFF00_0000_0000_0000;

  // window numbering, also the priority order (lower wins)
  localparam int unsigned WIN_REG = 2;
  localparam int unsigned WIN_INT = 3;

  typedef struct packed {
    word_t base;
    word_t size;
  } win_t;

  function automatic word_t keep_mask(input cfg_sel_e s);
    case (s)
      SEL_G0_BASE, SEL_G0_MASK,
      SEL_G1_BASE, SEL_G1_MASK: keep_mask = KEEP_GWIN;
      SEL_REG_BASE:             keep_mask = KEEP_RWIN;
      SEL_INT_BASE:             keep_mask = KEEP_IWIN;
      SEL_ENABLE:               keep_mask = KEEP_EN;
      default:                  keep_mask = KEEP_MODE;
    endcase
  endfunction
endpackage

// File: rtl/wdec_cfg_regs.sv
module wdec_cfg_regs
  import wdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [SEL_W-1:0]     sel,
  input  word_t                wdata,
  output word_t                rdata,
  output word_t [NUM_GWIN-1:0] gw_base,
  output word_t [NUM_GWIN-1:0] gw_mask,
  output word_t                rw_base,
  output word_t                iw_base,
  output logic  [NUM_WIN-1:0]  en_q,
  output logic  [NUM_WIN-1:0]  en_d,
  output logic                 warn
);
  word_t [NUM_CFG-1:0] regs_q;
  logic                conflict;
  logic                warn_q;
  logic                en_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (we) begin
      for (int k = 0; k < NUM_CFG; k++) begin
        if (sel == SEL_W'(k)) regs_q[k] <= wdata & keep_mask(cfg_sel_e'(k));
      end
    end
  end

  assign en_wr = we && (cfg_sel_e'(sel) == SEL_ENABLE);

  // enable bits sit at the top of the enable register, window 0 highest
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_en
    assign en_q[g] = regs_q[SEL_ENABLE][ADDR_W-1-g];
    assign en_d[g] = en_wr ? wdata[ADDR_W-1-g] : en_q[g];
  end

  for (genvar g = 0; g < NUM_GWIN; g++) begin : g_gw
    assign gw_base[g] = regs_q[2*g];
    assign gw_mask[g] = regs_q[2*g+1];
  end

  assign rw_base = regs_q[SEL_REG_BASE];
  assign iw_base = regs_q[SEL_INT_BASE];
  assign rdata   = regs_q[sel];

  always_comb begin
    case (cfg_sel_e'(sel))
      SEL_G0_BASE, SEL_G0_MASK,
      SEL_G1_BASE, SEL_G1_MASK: conflict = |en_q[NUM_GWIN-1:0];
      SEL_REG_BASE:             conflict = en_q[WIN_REG];
      SEL_INT_BASE:             conflict = en_q[WIN_INT];
      default:                  conflict = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= we && conflict;
  end

  assign warn = warn_q;
endmodule

// File: rtl/wdec_win_hold.sv
module wdec_win_hold
  import wdec_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_WIN-1:0]  en_q,
  input  logic [NUM_WIN-1:0]  en_d,
  input  win_t [NUM_WIN-1:0]  cand,
  output logic [NUM_WIN-1:0]  act,
  output win_t [NUM_WIN-1:0]  held
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_hold
    win_t held_q;
    logic act_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held_q <= '0;
        act_q  <= 1'b0;
      end else begin
        // capture only on the 0 -> 1 transition of this window's enable
        if (en_d[g] && !en_q[g]) held_q <= cand[g];
        act_q <= en_d[g];
      end
    end

    assign held[g] = held_q;
    assign act[g]  = act_q;
  end
endmodule

// File: rtl/wdec_match.sv
module wdec_match
  import wdec_pkg::*;
(
  input  word_t               addr,
  input  logic [NUM_WIN-1:0]  act,
  input  win_t [NUM_WIN-1:0]  win,
  output logic [NUM_WIN-1:0]  hit,
  output logic                miss,
  output word_t               offset
);
  logic  [NUM_WIN-1:0] raw;
  word_t [NUM_WIN-1:0] delta;

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign delta[g] = addr - win[g].base;
    assign raw[g]   = act[g] && (addr >= win[g].base) && (delta[g] < win[g].size);
  end

  always_comb begin
    logic found;
    found  = 1'b0;
    hit    = '0;
    offset = '0;
    for (int k = 0; k < NUM_WIN; k++) begin
      if (raw[k] && !found) begin
        found  = 1'b1;
        hit[k] = 1'b1;
        offset = delta[k];
      end
    end
    miss = !found;
  end
endmodule

// File: rtl/window_decoder.sv
module window_decoder
  import wdec_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned NUM_INTS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [ADDR_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0]  cfg_rdata,
  output logic               cfg_warn,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ADDR_W-1:0]  in_addr,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [NUM_WIN-1:0] out_hit,
  output logic               out_miss,
  output logic [ADDR_W-1:0]  out_offset
);
  localparam word_t RWIN_SIZE = word_t'(NUM_REGS) * word_t'(8);
  localparam word_t IWIN_SIZE = word_t'(NUM_INTS) << 16;

  word_t [NUM_GWIN-1:0] gw_base;
  word_t [NUM_GWIN-1:0] gw_mask;
  word_t                rw_base;
  word_t                iw_base;
  logic  [NUM_WIN-1:0]  en_q;
  logic  [NUM_WIN-1:0]  en_d;
  win_t  [NUM_WIN-1:0]  cand;
  win_t  [NUM_WIN-1:0]  held;
  logic  [NUM_WIN-1:0]  act;
  logic  [NUM_WIN-1:0]  m_hit;
  logic                 m_miss;
  word_t                m_off;

  wdec_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel     (cfg_sel),
    .wdata   (cfg_wdata),
    .rdata   (cfg_rdata),
    .gw_base (gw_base),
    .gw_mask (gw_mask),
    .rw_base (rw_base),
    .iw_base (iw_base),
    .en_q    (en_q),
    .en_d    (en_d),
    .warn    (cfg_warn)
  );

  for (genvar g = 0; g < NUM_GWIN; g++) begin : g_gcand
    assign cand[g].base = gw_base[g] >> BASE_SHIFT;
    assign cand[g].size = ((~gw_mask[g]) >> BASE_SHIFT) + word_t'(1);
  end
  assign cand[WIN_REG].base = rw_base >> BASE_SHIFT;
  assign cand[WIN_REG].size = RWIN_SIZE;
  assign cand[WIN_INT].base = iw_base >> BASE_SHIFT;
  assign cand[WIN_INT].size = IWIN_SIZE;

  wdec_win_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .en_q  (en_q),
    .en_d  (en_d),
    .cand  (cand),
    .act   (act),
    .held  (held)
  );

  wdec_match u_match (
    .addr   (in_addr),
    .act    (act),
    .win    (held),
    .hit    (m_hit),
    .miss   (m_miss),
    .offset (m_off)
  );

  logic                 vld_q;
  logic [NUM_WIN-1:0]   hit_q;
  logic                 miss_q;
  word_t                off_q;
  logic                 take;

  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= '0;
      miss_q <= 1'b0;
      off_q  <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      hit_q  <= m_hit;
      miss_q <= m_miss;
      off_q  <= m_off;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_hit    = hit_q;
  assign out_miss   = miss_q;
  assign out_offset = off_q;
endmodule

// File: rtl/wdec_checker.sv
module wdec_checker
  import wdec_pkg::*;
#(
  parameter int unsigned NUM_REGS = 256,
  parameter int unsigned NUM_INTS = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [SEL_W-1:0]   cfg_sel,
  input logic [ADDR_W-1:0]  cfg_rdata,
  input logic               cfg_warn,
  input logic               out_valid,
  input logic               out_ready,
  input logic [NUM_WIN-1:0] out_hit,
  input logic               out_miss,
  input logic [ADDR_W-1:0]  out_offset
);
  localparam logic [ADDR_W-1:0] RSPAN = 64'(NUM_REGS) * 64'd8;
  localparam logic [ADDR_W-1:0] ISPAN = 64'(NUM_INTS) << 16;

  a_r7_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_hit));

  a_r6_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_hit == '0 && out_offset == '0));

  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_miss) && $stable(out_offset)));

  a_r5_reg_span: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit[WIN_REG]) |-> (out_offset < RSPAN));

  a_r5_int_span: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_hit[WIN_INT]) |-> (out_offset < ISPAN));

  a_r3_enable_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == SEL_ENABLE) |-> (cfg_rdata[ADDR_W-5:0] == '0));

  a_r8_warn_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_warn |-> $past(cfg_we));
endmodule

bind window_decoder wdec_checker #(
  .NUM_REGS (NUM_REGS),
  .NUM_INTS (NUM_INTS)
) u_wdec_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_rdata  (cfg_rdata),
  .cfg_warn   (cfg_warn),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_hit    (out_hit),
  .out_miss   (out_miss),
  .out_offset (out_offset)
);

// File: tb/test_window_decoder.sv
module test_window_decoder;
  localparam int unsigned NREG = 256;
  localparam int unsigned NINT = 16;
  localparam logic [63:0] RSZ = 64'(NREG) * 64'd8;
  localparam logic [63:0] ISZ = 64'(NINT) << 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        cfg_warn;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [3:0]  out_hit;
  logic        out_miss;
  logic [63:0] out_offset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  window_decoder #(.NUM_REGS(NREG), .NUM_INTS(NINT)) i_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_warn(cfg_warn),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_miss(out_miss), .out_offset(out_offset)
  );

  // bench model
  logic [63:0] sh [8];
  logic [3:0]  en;
  logic [63:0] wbase [4];
  logic [63:0] wsize [4];

  function automatic logic [63:0] bkeep(input int s);
    case (s)
      0, 1, 2, 3: return 64'hFFFF_FFFF_FF00_0000;
      4:          return 64'hFFFF_FFFF_FFC0_0000;
      5:          return 64'hFFFF_FFF0_0000_0000;
      6:          return 64'hF000_0000_0000_0000;
      default:    return 64'hFF00_0000_0000_0000;
    endcase
  endfunction

  function automatic bit exp_warn(input int s);
    if (s <= 3) return en[0] | en[1];
    if (s == 4) return en[2];
    if (s == 5) return en[3];
    return 1'b0;
  endfunction

  task automatic model_write(input int s, input logic [63:0] d);
    logic [3:0] nen;
    sh[s] = d & bkeep(s);
    if (s == 6) begin
      for (int i = 0; i < 4; i++) nen[i] = sh[6][63-i];
      for (int i = 0; i < 4; i++) begin
        if (nen[i] && !en[i]) begin
          case (i)
            0: begin wbase[0] = sh[0] >> 8; wsize[0] = ((~sh[1]) >> 8) + 64'd1; end
            1: begin wbase[1] = sh[2] >> 8; wsize[1] = ((~sh[3]) >> 8) + 64'd1; end
            2: begin wbase[2] = sh[4] >> 8; wsize[2] = RSZ; end
            default: begin wbase[3] = sh[5] >> 8; wsize[3] = ISZ; end
          endcase
        end
      end
      en = nen;
    end
  endtask

  task automatic exp_lookup(input logic [63:0] a, output logic [3:0] h,
                            output logic [63:0] o);
    h = '0; o = '0;
    for (int i = 0; i < 4; i++) begin
      if (h == 0 && en[i] && a >= wbase[i] && (a - wbase[i]) < wsize[i]) begin
        h[i] = 1'b1;
        o = a - wbase[i];
      end
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_result(input string req, input logic [3:0] h,
                              input logic [63:0] o);
    chk(req, "out_valid", 64'(out_valid), 64'd1);
    chk(req, "out_hit", 64'(out_hit), 64'(h));
    chk(req, "out_miss", 64'(out_miss), 64'(h == 0));
    chk(req, "out_offset", out_offset, o);
  endtask

  task automatic wr(input string req, input int s, input logic [63:0] d);
    bit w;
    w = exp_warn(s);
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(req, "cfg_warn", 64'(cfg_warn), 64'(w));
    model_write(s, d);
  endtask

  task automatic rb(input string req, input int s);
    cfg_sel = 3'(s);
    #1;
    chk(req, "readback", cfg_rdata, sh[s]);
  endtask

  task automatic lk(input string req, input logic [63:0] a);
    logic [3:0] h; logic [63:0] o;
    exp_lookup(a, h, o);
    out_ready = 1'b1; in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check_result(req, h, o);
  endtask

  // lookup accepted on the same edge as a configuration write
  task automatic lk_with_wr(input string req, input logic [63:0] a,
                            input int s, input logic [63:0] d);
    logic [3:0] h; logic [63:0] o;
    exp_lookup(a, h, o);
    out_ready = 1'b1; in_valid = 1'b1; in_addr = a;
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_wdata = d;
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    check_result(req, h, o);
    model_write(s, d);
  endtask

  localparam logic [63:0] B0 = 64'h0000_0010_0000_0000;
  localparam logic [63:0] B1 = 64'h0000_0020_0000_0000;
  localparam logic [63:0] BR = 64'h0000_0030_0000_0000;
  localparam logic [63:0] BI = 64'h0000_0040_0000_0000;
  localparam logic [63:0] M1M = 64'hFFFF_FFFF_F000_0000;

  initial begin
    logic [3:0] h1; logic [63:0] o1;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) sh[i] = '0;
    for (int i = 0; i < 4; i++) begin wbase[i] = '0; wsize[i] = '0; end
    en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk("R11", "out_valid", 64'(out_valid), 64'd0);
    chk("R11", "cfg_warn", 64'(cfg_warn), 64'd0);
    chk("R11", "in_ready", 64'(in_ready), 64'd1);
    for (int i = 0; i < 8; i++) rb("R11", i);
    lk("R11", 64'h0);

    // R1 / R2 write masking
    for (int i = 0; i < 6; i++) begin
      wr("R1", i, '1);
      rb(i < 4 ? "R1" : "R2", i);
    end
    wr("R2", 7, '1);  rb("R2", 7);
    wr("R3", 6, 64'h0FFF_FFFF_FFFF_FFFF); rb("R3", 6);
    wr("R3", 6, 64'h0);

    // program the four windows, then enable all
    wr("R4", 0, B0 << 8); wr("R4", 1, M1M);
    wr("R4", 2, B1 << 8); wr("R4", 3, M1M);
    wr("R5", 4, BR << 8); wr("R5", 5, BI << 8);
    wr("R3", 6, 64'hF000_0000_0000_0000);
    lk("R4", B0);
    lk("R4", B0 + 64'h000F_FFFF);
    lk("R4", B0 + 64'h0010_0000);
    lk("R4", B0 - 64'd1);
    lk("R4", B1 + 64'd5);
    lk("R5", BR + RSZ - 64'd1);
    lk("R5", BR + RSZ);
    lk("R5", BI + 64'h1234);
    lk("R5", BI + ISZ);
    lk("R6", 64'hFFFF_FFFF_FFFF_FFF0);

    // R7 overlap priority, R3 disable takes effect
    wr("R8", 6, 64'h0);
    wr("R7", 2, B0 << 8);
    wr("R7", 6, 64'hF000_0000_0000_0000);
    lk("R7", B0 + 64'h400);
    wr("R3", 6, 64'h7000_0000_0000_0000);
    lk("R3", B0 + 64'h400);

    // R8 / R9 reprogramming a live window
    wr("R8", 2, B1 << 8);
    rb("R8", 2);
    lk("R9", B0 + 64'h400);
    lk("R9", B1 + 64'h400);
    wr("R8", 4, (BR + 64'h0010_0000) << 8);
    lk("R9", BR + 64'h10);
    wr("R8", 0, (B0 + 64'h0100_0000) << 8);
    wr("R8", 7, '1);
    wr("R3", 6, 64'h2000_0000_0000_0000);
    wr("R8", 5, (BI + 64'h10_0000_0000) << 8);
    wr("R9", 6, 64'hE000_0000_0000_0000);
    lk("R9", BR + 64'h0010_0000 + 64'h10);
    lk("R9", B1 + 64'h400);

    // R3 same-cycle enable write and lookup
    lk_with_wr("R3", B1 + 64'h8, 6, 64'h0);
    lk("R3", B1 + 64'h8);

    // R10 back-pressure
    wr("R10", 6, 64'hF000_0000_0000_0000);
    exp_lookup(B0 + 64'h20, h1, o1);
    out_ready = 1'b0; in_valid = 1'b1; in_addr = B0 + 64'h20;
    @(negedge clk);
    check_result("R10", h1, o1);
    in_addr = B1 + 64'h40;
    chk("R10", "in_ready", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    check_result("R10", h1, o1);
    exp_lookup(B1 + 64'h40, h1, o1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_result("R10", h1, o1);
    @(negedge clk);
    chk("R10", "out_valid", 64'(out_valid), 64'd0);

    // constrained random configurations and lookups
    for (int r = 0; r < 6; r++) begin
      wr("R3", 6, 64'h0);
      for (int s = 0; s < 6; s++) wr("R1", s, {$urandom(), $urandom()});
      wr("R3", 6, {4'($urandom()), 60'h0});
      for (int n = 0; n < 60; n++) begin
        int w;
        logic [63:0] a;
        w = int'($urandom() % 4);
        if ($urandom() % 5 == 0) a = {$urandom(), $urandom()};
        else a = wbase[w] + ({$urandom(), $urandom()} % (wsize[w] * 64'd2 + 64'd1));
        lk(n % 2 == 0 ? "R4" : "R7", a);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule